// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host-side master for a 12-bit sampling converter that returns each result over a three-wire serial link. The converter has a chip-select pin, a clock pin driven by the host and a data pin. Each request makes the block assert chip select, wait a programmable setup time, and run exactly sixteen serial clock periods. It derives the serial clock from the system clock, using a programmable half-period. It collects the sixteen returned bits and publishes the 12-bit value with a one-cycle strobe. It then holds chip select high for a programmable gap, so that the converter's acquisition and quiet-time minimums are met before the next frame.

The converter drives its first leading zero when chip select falls and launches each later bit on a serial clock falling edge. By default the block samples the data line at each falling edge it generates. With a fast serial clock, the last bit is only valid at the sixteenth falling edge. When the serial clock is slow, a mode input switches sampling to the rising edges instead. A start pulse that arrives during a frame is remembered and served after the gap. A continuous-mode input makes the block run frames back to back.

All timing inputs are counts of system clock cycles. A count of zero is treated as one. The configuration inputs are expected to stay stable while a frame runs.

Top module: `adc_frame_reader`

## Requirements
- R1: During and just after a synchronous reset, chip select and the serial clock are high, and busy, done, the result and the frame-error flag are all zero.
- R2: Each frame holds chip select low for exactly 16 serial clock falling edges. The serial clock is high whenever chip select is high.
- R3: After chip select falls, the serial clock stays high for max(setup,1) system cycles before its first falling edge. Each later low or high phase lasts max(half,1) cycles.
- R4: In falling-edge mode (mode input 0), the data line is sampled at each of the 16 system clock edges that drive the serial clock low. The bits arrive MSB first, and the last 12 bits form the result, MSB first.
- R5: In rising-edge mode (mode input 1), the data line is sampled at the first 15 rising edges of the frame. Rising edge n captures bit n, where bit 0 is the one present when chip select falls. Bit 0 is never sampled and counts as zero.
- R6: The frame-error flag is set with each result when any sampled bit among the first four (the leading zeros) is one, and cleared otherwise.
- R7: Done is high for exactly one system cycle per frame: the cycle in which the serial clock is low for the 16th time. The result changes only in that cycle.
- R8: Chip select rises one low phase after the 16th falling edge, in the same cycle as the serial clock returns high. Chip select is therefore low for max(setup,1) + 31*max(half,1) cycles.
- R9: Between two frames, chip select stays high for max(gap,1)+1 system cycles when the next frame was already requested. In continuous mode the frames repeat with exactly that gap.
- R10: A start pulse that arrives while a frame or gap is in progress is held and served after the gap. Any number of such pulses during one frame yields exactly one extra frame.
- R11: Busy is high from the cycle after a start is accepted until the gap after the last frame has ended. Busy is low whenever chip select is high and no frame or gap is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame (sampled each cycle) |
| cont_i | input | 1 | Run frames back to back while high |
| rise_mode_i | input | 1 | 0: sample on falling edges, 1: sample on rising edges |
| half_cyc_i | input | HALF_W | Serial clock half-period in system cycles |
| setup_cyc_i | input | SETUP_W | Chip-select-to-first-edge setup in system cycles |
| gap_cyc_i | input | GAP_W | Post-frame quiet gap in system cycles |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| busy_o | output | 1 | Frame or gap in progress |
| done_o | output | 1 | One-cycle strobe with a new result |
| result_o | output | 12 | Last converted value |
| frame_err_o | output | 1 | A leading-zero bit was sampled as one |

## Verification
The assertions check the pin relationships on every cycle. They check that the serial clock is idle high while chip select is high, and that every frame holds sixteen falling edges. They check that done is a single-cycle pulse in a low clock phase, and that the result moves only with done. Only the bench scenarios can show the timing and the data. These cover the exact setup, half-period and gap lengths for many settings, the bit order and leading-zero checks in both sampling modes, and the treatment of zero counts. They also cover how start pulses that arrive mid-frame collapse into a single extra frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FRAME_BITS = 16;
    localparam int LEAD_BITS  = 4;
    localparam int RES_BITS   = FRAME_BITS - LEAD_BITS;
    localparam int EDGE_W     = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } rd_state_e;

    typedef struct packed {
        logic [RES_BITS-1:0] value;
        logic                frame_err;
    } rd_result_t;

    // Last count value of a phase lasting max(cyc,1) cycles.
    function automatic int unsigned phase_last(input int unsigned cyc);
        return (cyc == 0) ? 0 : cyc - 1;
    endfunction

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [N-1:0] word_next
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [N-1:0] sh_q;

    always_comb begin
        if (clear)
            word_next = '0;
        else if (shift_en)
            word_next = {sh_q[N-2:0], din};
        else
            word_next = sh_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else
            sh_q <= word_next;
    end
endmodule

// File: rtl/adc_rd_request.sv
module adc_rd_request (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cont,
    input  logic idle,
    output logic req
);
    timeunit 1ns;
    timeprecision 1ps;

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (idle)
            pend_q <= 1'b0;
        else if (start)
            pend_q <= 1'b1;
    end

    assign req = start | cont | pend_q;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int SETUP_W = 8,
    parameter int GAP_W   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                cont_i,
    input  logic                rise_mode_i,
    input  logic [HALF_W-1:0]   half_cyc_i,
    input  logic [SETUP_W-1:0]  setup_cyc_i,
    input  logic [GAP_W-1:0]    gap_cyc_i,
    input  logic                sdata_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                frame_err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TMR_W = wmax(wmax(HALF_W, SETUP_W), GAP_W);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_BITS);

    rd_state_e        st_q, st_n;
    logic [EDGE_W-1:0] fcnt_q, fcnt_n;
    rd_result_t       res_q;
    logic             done_q;

    logic             req, t_exp, t_load, sh_en, sh_clr, fin;
    logic [TMR_W-1:0] t_val, half_ld, setup_ld, gap_ld;
    logic [FRAME_BITS-1:0] word_next;

    assign half_ld  = TMR_W'(phase_last(32'(half_cyc_i)));
    assign setup_ld = TMR_W'(phase_last(32'(setup_cyc_i)));
    assign gap_ld   = TMR_W'(phase_last(32'(gap_cyc_i)));

    adc_rd_request req_i (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .cont  (cont_i),
        .idle  (st_q == ST_IDLE),
        .req   (req)
    );

    adc_rd_timer #(.W(TMR_W)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    adc_rd_shift #(.N(FRAME_BITS)) shf_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (sh_clr),
        .shift_en  (sh_en),
        .din       (sdata_i),
        .word_next (word_next)
    );

    always_comb begin
        st_n   = st_q;
        fcnt_n = fcnt_q;
        t_load = 1'b0;
        t_val  = '0;
        sh_en  = 1'b0;
        sh_clr = 1'b0;
        fin    = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    st_n   = ST_SETUP;
                    t_load = 1'b1;
                    t_val  = setup_ld;
                    sh_clr = 1'b1;
                    fcnt_n = '0;
                end
            end
            ST_SETUP: begin
                if (t_exp) begin
                    st_n   = ST_LOW;
                    t_load = 1'b1;
                    t_val  = half_ld;
                    fcnt_n = EDGE_W'(1);
                    sh_en  = !rise_mode_i;
                end
            end
            ST_LOW: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (fcnt_q == LAST_EDGE) begin
                        st_n  = ST_GAP;
                        t_val = gap_ld;
                    end else begin
                        st_n  = ST_HIGH;
                        t_val = half_ld;
                        sh_en = rise_mode_i;
                    end
                end
            end
            ST_HIGH: begin
                if (t_exp) begin
                    st_n   = ST_LOW;
                    t_load = 1'b1;
                    t_val  = half_ld;
                    fcnt_n = fcnt_q + 1'b1;
                    sh_en  = !rise_mode_i;
                    fin    = (fcnt_n == LAST_EDGE);
                end
            end
            ST_GAP: begin
                if (t_exp)
                    st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            fcnt_q <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            fcnt_q <= fcnt_n;
            done_q <= fin;
            if (fin) begin
                res_q.value     <= word_next[RES_BITS-1:0];
                res_q.frame_err <= |word_next[FRAME_BITS-1:RES_BITS];
            end
        end
    end

    assign cs_n_o      = (st_q == ST_IDLE) || (st_q == ST_GAP);
    assign sclk_o      = (st_q != ST_LOW);
    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = done_q;
    assign result_o    = res_q.value;
    assign frame_err_o = res_q.frame_err;
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker
    import adc_rd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cs_n,
    input logic                sclk,
    input logic                busy,
    input logic                done,
    input logic [RES_BITS-1:0] result
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [EDGE_W:0] falls_q;
    logic            sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            falls_q <= '0;
            sclk_q  <= 1'b1;
        end else begin
            sclk_q <= sclk;
            if (cs_n)
                falls_q <= '0;
            else if (sclk_q && !sclk)
                falls_q <= falls_q + 1'b1;
        end
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    assert_sixteen_falls_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (falls_q == (EDGE_W+1)'(FRAME_BITS)));

    assert_cs_fall_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (sclk && busy));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_low_phase_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sclk && !cs_n));

    assert_result_moves_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    assert_idle_deselect_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);
endmodule

bind adc_frame_reader adc_rd_checker chk_i (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n_o),
    .sclk   (sclk_o),
    .busy   (busy_o),
    .done   (done_o),
    .result (result_o)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cont = 1'b0;
    logic        rise = 1'b0;
    logic [7:0]  half = 8'd1;
    logic [7:0]  setup = 8'd1;
    logic [9:0]  gap = 10'd1;
    logic        sdata = 1'b0;
    logic        cs_n, sclk, busy, done, ferr;
    logic [11:0] result;
    logic [15:0] cur_word = 16'h0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bit_k = 0;
    bit mon_en = 1'b0;
    bit prev_cs = 1'b1;
    bit prev_sclk = 1'b1;
    bit seen_fall = 1'b0;
    int low_len = 0, hi_len = 0, setup_len = 0, falls = 0, last_hi = 0, dones = 0;

    always #2.5 clk = ~clk;

    adc_frame_reader dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .cont_i      (cont),
        .rise_mode_i (rise),
        .half_cyc_i  (half),
        .setup_cyc_i (setup),
        .gap_cyc_i   (gap),
        .sdata_i     (sdata),
        .cs_n_o      (cs_n),
        .sclk_o      (sclk),
        .busy_o      (busy),
        .done_o      (done),
        .result_o    (result),
        .frame_err_o (ferr)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_err(input logic [15:0] w, input logic r);
        return r ? int'(|w[14:12]) : int'(|w[15:12]);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    // Converter model: first bit on chip-select fall, next bits after each falling clock edge.
    always @(negedge cs_n or negedge sclk) begin
        if (!cs_n) begin
            if (sclk) bit_k = 0;
            else bit_k = bit_k + 1;
            if (bit_k < 16) sdata <= #1 cur_word[15 - bit_k];
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (mon_en) begin
            if (!cs_n) begin
                if (prev_cs) begin
                    last_hi = hi_len; low_len = 0; falls = 0; setup_len = 0; seen_fall = 0;
                end
                low_len++;
                if (prev_sclk && !sclk) falls++;
                if (!sclk) seen_fall = 1;
                if (!seen_fall) setup_len++;
            end else begin
                if (!prev_cs) begin
                    check(falls == 16, "R2", falls, 16);
                    check(sclk == 1'b1, "R8", sclk, 1);
                    check(setup_len == eff(setup), "R3", setup_len, eff(setup));
                    check(low_len == eff(setup) + 31 * eff(half), "R8", low_len,
                          eff(setup) + 31 * eff(half));
                    hi_len = 0;
                end
                hi_len++;
            end
            if (done) begin
                dones++;
                check(falls == 16 && !sclk, "R7", falls, 16);
                check(result == cur_word[11:0], rise ? "R5" : "R4", result, cur_word[11:0]);
                check(int'(ferr) == exp_err(cur_word, rise), "R6", ferr, exp_err(cur_word, rise));
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] w, input logic r, input int h, input int s, input int g);
        int d0;
        @(negedge clk);
        cur_word = w; rise = r; half = 8'(h); setup = 8'(s); gap = 10'(g);
        d0 = dones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", busy, 1);
        wait_idle();
        check(dones == d0 + 1, "R7", dones - d0, 1);
        check(cs_n && sclk && !busy, "R11", {cs_n, sclk, busy}, 3'b110);
    endtask

    initial begin
        int d0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_n == 1 && sclk == 1, "R1", {cs_n, sclk}, 2'b11);
        check(busy == 0 && done == 0 && result == 0 && ferr == 0, "R1",
              {busy, done, ferr, result}, 0);
        rst = 1'b0;
        @(negedge clk);
        mon_en = 1'b1;
        check(cs_n == 1 && busy == 0, "R1", {cs_n, busy}, 2'b10);

        // R4 / R6: falling-edge mode
        run_frame(16'h0ABC, 1'b0, 2, 1, 3);
        run_frame(16'h8123, 1'b0, 1, 2, 1);
        run_frame(16'h1FFF, 1'b0, 3, 1, 2);
        run_frame(16'h0000, 1'b0, 1, 1, 1);
        run_frame(16'h0FFF, 1'b0, 1, 1, 1);
        // R5: rising-edge mode, bit 0 not sampled
        run_frame(16'h8555, 1'b1, 2, 1, 2);
        run_frame(16'h2555, 1'b1, 2, 3, 2);
        run_frame(16'h0A5A, 1'b1, 4, 2, 1);
        // R3: zero counts act as one
        run_frame(16'h0321, 1'b0, 0, 0, 0);

        // R9: continuous mode gap
        @(negedge clk);
        cur_word = 16'h0777; rise = 1'b0; half = 8'd1; setup = 8'd2; gap = 10'd5;
        d0 = dones;
        cont = 1'b1;
        while (dones < d0 + 3) @(negedge clk);
        cont = 1'b0;
        wait_idle();
        check(dones == d0 + 3, "R9", dones - d0, 3);
        check(last_hi == eff(5) + 1, "R9", last_hi, eff(5) + 1);

        // R10: start pulses during a frame coalesce into one held request
        @(negedge clk);
        cur_word = 16'h0B0B; rise = 1'b0; half = 8'd2; setup = 8'd1; gap = 10'd4;
        d0 = dones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (dones < d0 + 2) @(negedge clk);
        wait_idle();
        repeat (20) @(negedge clk);
        check(dones == d0 + 2, "R10", dones - d0, 2);
        check(last_hi == eff(4) + 1, "R10", last_hi, eff(4) + 1);

        // Random frames
        for (int i = 0; i < 24; i++) begin
            run_frame(16'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 4)), int'($urandom_range(0, 6)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule